// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block converts one decimal digit at a time from BCD to excess-3 code. The digit arrives on a single serial line, least significant bit first, one bit per consumed clock over four consumed clocks (t0 to t3). On the same clock that each input bit is presented, the block drives the matching bit of the digit plus three. The output is therefore Mealy-type: it depends on the current state and on the input bit of that same cycle.

Internally the block is a seven-state machine held in three flip-flops. The states track the bit position within the digit and the running carry of the serial addition of 0011. After the fourth bit the machine always returns to its start state, so digits may follow one another with no idle cycle. A bit-valid strobe lets the source pause between bits. While the strobe is low, no bit is consumed and the output line keeps the last bit it produced. Input codes 10 to 15 are not detected, and their output bits are unspecified.

Top module: `xs3_serial_conv`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, returns the machine to the start state from any position in a digit. After reset, with bit_vld_i low, ser_dout_o is 0.
- R2: In the start state with bit_vld_i high, the output is the inverse of the input bit in the same cycle: input 0 gives 1, and input 1 gives 0.
- R3: For every BCD digit d from 0 to 9, sent least significant bit first on four consumed clocks, the four output bits in time order are the bits of (d+3) as a 4-bit binary value, least significant bit first.
- R4: The output is combinational in the current input bit. Within one cycle and with no clock edge in between, changing ser_din_i changes ser_dout_o.
- R5: After the fourth consumed bit the machine is back in the start state unconditionally. A new digit may start on the very next clock.
- R6: While bit_vld_i is low, no bit is consumed and the state does not change. During that time ser_dout_o holds the last bit produced, whatever the value of ser_din_i.
- R7: The input bits 0,0,0,0 (t0 to t3) produce the output bits 1,1,0,0 in the same time order.
- R8: After any invalid code (10 to 15) the four-clock framing is unaffected, and the next valid digit converts correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_vld_i | input | 1 | High when ser_din_i carries a bit to be consumed this clock |
| ser_din_i | input | 1 | Serial BCD input, least significant bit first |
| ser_dout_o | output | 1 | Serial excess-3 output, least significant bit first |

## Verification
A wrong carry state appears at the ports in the same digit. It corrupts the output bit of the next consumed clock, or of a later bit in that digit, as a difference from digit plus three. A wrong position state is seen at the latest on the following digit, because the framing then slips and that digit's bits come out shifted or carried wrongly. Held-state faults show up on the first bit after an idle gap, and output-hold faults show up during the gap itself.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

    localparam int unsigned ST_W = 3;

    // Position within the digit and running carry; 3'b111 is unused.
    typedef enum logic [ST_W-1:0] {
        ST_T0    = 3'b000,
        ST_T1_C0 = 3'b001,
        ST_T1_C1 = 3'b011,
        ST_T2_C0 = 3'b010,
        ST_T2_C1 = 3'b110,
        ST_T3_C0 = 3'b100,
        ST_T3_C1 = 3'b101
    } xs3_state_e;

    typedef struct packed {
        xs3_state_e state;
        logic       dout;
    } xs3_regs_t;

endpackage

// File: rtl/xs3_step.sv
module xs3_step
    import xs3_pkg::*;
(
    input  xs3_state_e state_i,
    input  logic       din_i,
    output xs3_state_e next_o,
    output logic       dout_o
);

    // Serial add of 0011: addend bit is 1 at t0 and t1, 0 at t2 and t3.
    always_comb begin
        next_o = ST_T0;
        dout_o = 1'b0;
        unique case (state_i)
            ST_T0: begin
                dout_o = ~din_i;
                next_o = din_i ? ST_T1_C1 : ST_T1_C0;
            end
            ST_T1_C0: begin
                dout_o = ~din_i;
                next_o = din_i ? ST_T2_C1 : ST_T2_C0;
            end
            ST_T1_C1: begin
                dout_o = din_i;
                next_o = ST_T2_C1;
            end
            ST_T2_C0: begin
                dout_o = din_i;
                next_o = ST_T3_C0;
            end
            ST_T2_C1: begin
                dout_o = ~din_i;
                next_o = din_i ? ST_T3_C1 : ST_T3_C0;
            end
            ST_T3_C0: begin
                dout_o = din_i;
                next_o = ST_T0;
            end
            ST_T3_C1: begin
                dout_o = ~din_i;
                next_o = ST_T0;
            end
            default: begin
                dout_o = 1'b0;
                next_o = ST_T0;
            end
        endcase
    end

endmodule

// File: rtl/xs3_serial_conv.sv
module xs3_serial_conv
    import xs3_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_vld_i,
    input  logic ser_din_i,
    output logic ser_dout_o
);

    xs3_regs_t  regs_d, regs_q;
    xs3_state_e step_next;
    logic       step_dout;

    xs3_step step_i (
        .state_i (regs_q.state),
        .din_i   (ser_din_i),
        .next_o  (step_next),
        .dout_o  (step_dout)
    );

    always_comb begin
        regs_d = regs_q;
        if (bit_vld_i) begin
            regs_d.state = step_next;
            regs_d.dout  = step_dout;
        end
        if (rst_i) begin
            regs_d.state = ST_T0;
            regs_d.dout  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign ser_dout_o = bit_vld_i ? step_dout : regs_q.dout;

    // R2
    start_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && regs_q.state == ST_T0) |=>
            (regs_q.state == ($past(ser_din_i) ? ST_T1_C1 : ST_T1_C0)));

    // R3
    advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && (regs_q.state == ST_T1_C0 || regs_q.state == ST_T1_C1)) |=>
            (regs_q.state == ST_T2_C0 || regs_q.state == ST_T2_C1));

    // R3
    legal_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(regs_q.state) < 3);

    // R5
    frame_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && (regs_q.state == ST_T3_C0 || regs_q.state == ST_T3_C1)) |=>
            (regs_q.state == ST_T0));

    // R6
    hold_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_vld_i |=> $stable(regs_q.state));

    // R6
    hold_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_vld_i |=> (!bit_vld_i -> (ser_dout_o == $past(ser_dout_o))));

endmodule

// File: tb/xs3_serial_conv_tb_top.sv
`timescale 1ns/1ps
module xs3_serial_conv_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic vld;
    logic din;
    logic dout;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xs3_serial_conv dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .bit_vld_i  (vld),
        .ser_din_i  (din),
        .ser_dout_o (dout)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One consumed bit, output checked in the same cycle before the edge.
    task automatic send_bit(input logic x, input bit do_chk, input logic exp, input string req);
        @(negedge clk);
        rst = 1'b0; vld = 1'b1; din = x;
        #1;
        if (do_chk) chk(req, dout, exp);
    endtask

    task automatic send_digit(input int d, input bit do_chk, input string req);
        logic [3:0] e;
        e = 4'(d + 3);
        for (int i = 0; i < 4; i++) send_bit(d[i], do_chk, e[i], req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld = 1'b0; din = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 reset output", dout, 1'b0);
    endtask

    task automatic t_all_digits();
        for (int d = 0; d < 10; d++) send_digit(d, 1'b1, "R3/R5 back-to-back digit");
    endtask

    task automatic t_zero_pattern();
        @(negedge clk);
        vld = 1'b1; din = 1'b0;
        #0.5;
        chk("R2 start input 0", dout, 1'b1);
        din = 1'b1;
        #0.5;
        chk("R4 same-cycle input 1", dout, 1'b0);
        din = 1'b0;
        #0.5;
        chk("R7 t0", dout, 1'b1);
        send_bit(1'b0, 1'b1, 1'b1, "R7 t1");
        send_bit(1'b0, 1'b1, 1'b0, "R7 t2");
        send_bit(1'b0, 1'b1, 1'b0, "R7 t3");
    endtask

    // Digit 6 with idle gaps: outputs 1,0,0,1.
    task automatic t_gaps();
        logic [3:0] e;
        e = 4'(6 + 3);
        for (int i = 0; i < 4; i++) begin
            send_bit(i[1] ^ i[0], 1'b1, e[i], "R6 bit after gap");
            for (int g = 0; g < 3; g++) begin
                @(negedge clk);
                vld = 1'b0; din = g[0];
                #1;
                chk("R6 output held", dout, e[i]);
            end
        end
        send_digit(2, 1'b1, "R6 digit after gaps");
    endtask

    task automatic t_invalid();
        for (int d = 10; d < 16; d++) send_digit(d, 1'b0, "");
        send_digit(4, 1'b1, "R8 digit after invalid codes");
        send_digit(9, 1'b1, "R8 second digit after invalid codes");
    endtask

    task automatic t_reset_mid();
        send_bit(1'b1, 1'b0, 1'b0, "");
        send_bit(1'b1, 1'b0, 1'b0, "");
        do_reset();
        send_digit(8, 1'b1, "R1 digit after mid-frame reset");
        send_digit(1, 1'b1, "R1 next digit after reset");
    endtask

    initial begin
        rst = 1'b1; vld = 1'b0; din = 1'b0;
        repeat (3) @(posedge clk);
        t_reset();
        t_all_digits();
        t_zero_pattern();
        t_gaps();
        t_invalid();
        t_reset_mid();
        @(negedge clk);
        vld = 1'b0;
        done = 1'b1;
        summary();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule